// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block puts a DRAM controller and its memory into the deepest power-saving state and brings them back. Software arms the mode with an enable bit and sets a 32-bit sensitivity threshold. The block counts how many consecutive cycles the controller has been idle with no request waiting. When that run is longer than the threshold, the block stops accepting requests and waits for in-flight work to finish. It then sends one refresh command with the clock enable low, which puts the memory into self-refresh, and on the next cycle it stops both internal clocks.

A request or a reset wakes the block. After a request, the clocks run again on the next cycle and the clock enable rises one cycle after that. One cycle later the block issues a mode-register-set that carries the stored mode word. Requests then stay blocked for a programmable number of cycles before the block accepts them again.

A request is a level: the requester holds `wake_req` high until it sees `req_accept`. If a request arrives while the block is still draining, the power-down is dropped and the block returns to normal service.

Top module: `srs_seq`

## Requirements
- R1: No power-down starts while `pd_en` is 0. While `pd_en` is 1, `req_accept` falls in the cycle after the (N+1)-th consecutive cycle with `ctl_idle`=1 and `wake_req`=0, where N is `sens_thresh`. If that run is broken sooner, the count starts again from zero.
- R2: Once a power-down has started, `req_accept` stays 0. `cmd_refresh` is issued only in the cycle after a cycle in which `ctl_idle` was 1. While `ctl_idle` is 0 the block keeps waiting.
- R3: `cmd_refresh` is a one-cycle strobe issued with `dram_cke` low. `dram_cke` stays low until the wake sequence releases it.
- R4: In the cycle after `cmd_refresh`, `clk_stop_core`, `clk_stop_ctrl` and `in_selfref` are all 1. They stay at 1 until a wake event.
- R5: When `wake_req` is 1 in a sleeping cycle, both clock-stop outputs are 0 in the next cycle, while `dram_cke` is still 0.
- R6: `dram_cke` returns to 1 in the cycle after the clocks resume.
- R7: `cmd_mrs` is a one-cycle strobe in the cycle after `dram_cke` rises. `mrs_data` equals `mode_data` during that strobe and is 0 at all other times.
- R8: After `cmd_mrs`, `req_accept` stays 0 for exactly `ready_dly` cycles and is 1 in the following cycle. A value of 0 gives acceptance in the very next cycle.
- R9: `wake_req`=1 while draining returns the block to normal service in the next cycle (`req_accept`=1), even if `ctl_idle` is 1, and no refresh is issued.
- R10: A synchronous `rst` from any state, including sleep, gives the following outputs in the next cycle: `req_accept`=1, `dram_cke`=1, both clock stops 0, both strobes 0, and `in_selfref`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst | input | 1 | Synchronous active-high reset, also a wake event |
| pd_en | input | 1 | Arms deep power-down |
| sens_thresh | input | 32 | Idle cycles that must be exceeded before entry |
| ctl_idle | input | 1 | Controller has no transaction outstanding |
| wake_req | input | 1 | New request present, held until accepted |
| mode_data | input | 16 | Stored mode word replayed on exit |
| ready_dly | input | 8 | Post-wake lockout in DRAM clocks (nominal 200) |
| cmd_refresh | output | 1 | Refresh command strobe (self-refresh entry) |
| cmd_mrs | output | 1 | Mode-register-set command strobe |
| mrs_data | output | 16 | Mode word carried with the MRS strobe |
| dram_cke | output | 1 | DRAM clock enable |
| clk_stop_core | output | 1 | Stops the request-path clock |
| clk_stop_ctrl | output | 1 | Stops the controller/refresh clock |
| req_accept | output | 1 | Controller may take a new request |
| in_selfref | output | 1 | Memory is held in self-refresh |

## Verification
Two events can fall in the same cycle: a new request and the completion of the drain (`ctl_idle`=1), both arriving while the block is draining. The bench provokes this by raising `wake_req` in the drain cycle with `ctl_idle` still high. It then expects `req_accept`=1 in the next cycle and no `cmd_refresh` over the following cycles. A second check drops `ctl_idle` during the drain to show that the refresh waits for it. A third check applies reset while the block is asleep to show that reset is also a wake event.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_SREF  = 3'd2,
        ST_SLEEP = 3'd3,
        ST_CLKON = 3'd4,
        ST_CKEON = 3'd5,
        ST_MRS   = 3'd6,
        ST_LOCK  = 3'd7
    } srs_state_e;

    typedef struct packed {
        logic refresh;
        logic mrs;
        logic cke;
        logic stop_core;
        logic stop_ctrl;
        logic accept;
        logic in_sr;
    } srs_ctl_t;

    function automatic srs_ctl_t srs_decode(input srs_state_e s);
        srs_ctl_t c;
        c = '0;
        c.cke = 1'b1;
        case (s)
            ST_RUN:   c.accept = 1'b1;
            ST_SREF: begin
                c.refresh = 1'b1;
                c.cke     = 1'b0;
            end
            ST_SLEEP: begin
                c.cke       = 1'b0;
                c.stop_core = 1'b1;
                c.stop_ctrl = 1'b1;
                c.in_sr     = 1'b1;
            end
            ST_CLKON: begin
                c.cke   = 1'b0;
                c.in_sr = 1'b1;
            end
            ST_MRS:   c.mrs = 1'b1;
            default:  ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/srs_idle_filter.sv
module srs_idle_filter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             idle,
    input  logic             wake,
    input  logic [CNT_W-1:0] thresh,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             cond;
    logic [CNT_W-1:0] run_q;

    assign cond = arm && idle && !wake;
    assign hit  = cond && (run_q >= thresh);

    always_ff @(posedge clk) begin
        if (rst || !cond)
            run_q <= '0;
        else if (run_q != CNT_MAX)
            run_q <= run_q + 1'b1;
    end

    // R1: the run counter only moves while the qualifying condition is held
    p_run_restart_r1: assert property (@(posedge clk) disable iff (rst)
        (!cond) |=> (run_q == '0));

endmodule

// File: rtl/srs_lock_timer.sv
module srs_lock_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [DLY_W-1:0] dly,
    output logic             last
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= dly;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == {{(DLY_W-1){1'b0}}, 1'b1});

    // R8: the lockout never counts down from an empty timer
    p_dec_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       idle,
    input  logic       wake,
    input  logic       dly_zero,
    input  logic       lock_last,
    output srs_state_e state_q
);
    srs_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:   if (hit) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (wake)      state_d = ST_RUN;
                else if (idle) state_d = ST_SREF;
            end
            ST_SREF:  state_d = ST_SLEEP;
            ST_SLEEP: if (wake) state_d = ST_CLKON;
            ST_CLKON: state_d = ST_CKEON;
            ST_CKEON: state_d = ST_MRS;
            ST_MRS:   state_d = dly_zero ? ST_RUN : ST_LOCK;
            ST_LOCK:  if (lock_last) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // R5: a wake seen while asleep resumes the clocks on the next cycle
    p_resume_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && wake) |=> (state_q == ST_CLKON));

    // R4: sleep persists without a wake
    p_sleep_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !wake) |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/srs_seq.sv
module srs_seq
    import srs_pkg::*;
#(
    parameter int SENS_W = 32,
    parameter int DLY_W  = 8,
    parameter int MODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_en,
    input  logic [SENS_W-1:0] sens_thresh,
    input  logic              ctl_idle,
    input  logic              wake_req,
    input  logic [MODE_W-1:0] mode_data,
    input  logic [DLY_W-1:0]  ready_dly,
    output logic              cmd_refresh,
    output logic              cmd_mrs,
    output logic [MODE_W-1:0] mrs_data,
    output logic              dram_cke,
    output logic              clk_stop_core,
    output logic              clk_stop_ctrl,
    output logic              req_accept,
    output logic              in_selfref
);
    srs_state_e st;
    srs_ctl_t   ctl;
    logic       hit;
    logic       lock_last;

    srs_idle_filter #(.CNT_W(SENS_W)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .arm    (pd_en && st == ST_RUN),
        .idle   (ctl_idle),
        .wake   (wake_req),
        .thresh (sens_thresh),
        .hit    (hit)
    );

    srs_lock_timer #(.DLY_W(DLY_W)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .load (st == ST_MRS),
        .dec  (st == ST_LOCK),
        .dly  (ready_dly),
        .last (lock_last)
    );

    srs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .idle      (ctl_idle),
        .wake      (wake_req),
        .dly_zero  (ready_dly == '0),
        .lock_last (lock_last),
        .state_q   (st)
    );

    assign ctl           = srs_decode(st);
    assign cmd_refresh   = ctl.refresh;
    assign cmd_mrs       = ctl.mrs;
    assign mrs_data      = ctl.mrs ? mode_data : '0;
    assign dram_cke      = ctl.cke;
    assign clk_stop_core = ctl.stop_core;
    assign clk_stop_ctrl = ctl.stop_ctrl;
    assign req_accept    = ctl.accept;
    assign in_selfref    = ctl.in_sr;

    // R1: leaving normal service requires the enable
    p_entry_needs_en_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && req_accept) ##1 (st == ST_DRAIN) |-> $past(pd_en));

    // R2: refresh only follows a sampled idle controller
    p_refresh_after_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_refresh |-> $past(ctl_idle));

    // R3 / R4: after the refresh the clock enable stays low and clocks stop
    p_clocks_off_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_refresh |=> (!dram_cke && clk_stop_core && clk_stop_ctrl && in_selfref));

    // R6: clock enable returns one cycle after clocks resume
    p_cke_after_clk_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_stop_core) && !$past(rst)) |-> (!dram_cke ##1 dram_cke));

    // R7: mode-register-set follows the clock enable release
    p_mrs_after_cke_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(dram_cke) && !$past(rst)) |=> cmd_mrs);

    // R9: a request during drain abandons the power-down
    p_abandon_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && wake_req) |=> (req_accept && !cmd_refresh));

endmodule

// File: tb/sim_srs_seq.sv
module sim_srs_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        pd_en;
    logic [31:0] sens_thresh;
    logic        ctl_idle;
    logic        wake_req;
    logic [15:0] mode_data;
    logic [7:0]  ready_dly;
    logic        cmd_refresh, cmd_mrs, dram_cke, clk_stop_core, clk_stop_ctrl;
    logic        req_accept, in_selfref;
    logic [15:0] mrs_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    srs_seq u0 (
        .clk(clk), .rst(rst), .pd_en(pd_en), .sens_thresh(sens_thresh),
        .ctl_idle(ctl_idle), .wake_req(wake_req), .mode_data(mode_data),
        .ready_dly(ready_dly), .cmd_refresh(cmd_refresh), .cmd_mrs(cmd_mrs),
        .mrs_data(mrs_data), .dram_cke(dram_cke), .clk_stop_core(clk_stop_core),
        .clk_stop_ctrl(clk_stop_ctrl), .req_accept(req_accept), .in_selfref(in_selfref)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pd_en = 1'b0; sens_thresh = '0; ctl_idle = 1'b0;
        wake_req = 1'b0; mode_data = 16'hA5C3; ready_dly = 8'd0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic chk_run_outputs(input string req);
        chk(req, "req_accept", req_accept, 1);
        chk(req, "cke", dram_cke, 1);
        chk(req, "stops", {clk_stop_core, clk_stop_ctrl}, 0);
        chk(req, "strobes", {cmd_refresh, cmd_mrs}, 0);
        chk(req, "in_selfref", in_selfref, 0);
    endtask

    // Drives idle from RUN until the block is asleep; checks R1..R4
    task automatic enter_sleep(input int thr);
        pd_en = 1'b1; sens_thresh = thr; ctl_idle = 1'b1; wake_req = 1'b0;
        for (int i = 1; i <= thr; i++) begin
            tick();
            chk("R1", "accept before threshold", req_accept, 1);
        end
        tick();
        chk("R1", "accept after threshold", req_accept, 0);
        tick();
        chk("R3", "refresh strobe", cmd_refresh, 1);
        chk("R3", "cke low with refresh", dram_cke, 0);
        tick();
        chk("R4", "clock stops", {clk_stop_core, clk_stop_ctrl}, 3);
        chk("R4", "in_selfref", in_selfref, 1);
        chk("R3", "refresh one cycle", cmd_refresh, 0);
    endtask

    // Wakes from sleep and checks R5..R8
    task automatic wake_up(input int dly);
        ready_dly = dly;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4", "sleep holds", {clk_stop_core, dram_cke}, 2);
        end
        wake_req = 1'b1;
        tick();
        chk("R5", "clocks resume", {clk_stop_core, clk_stop_ctrl}, 0);
        chk("R5", "cke still low", dram_cke, 0);
        tick();
        chk("R6", "cke released", dram_cke, 1);
        chk("R6", "no mrs yet", cmd_mrs, 0);
        tick();
        chk("R7", "mrs strobe", cmd_mrs, 1);
        chk("R7", "mrs data", mrs_data, 16'hA5C3);
        for (int i = 0; i < dly; i++) begin
            tick();
            chk("R8", "locked out", req_accept, 0);
            chk("R7", "mrs data idle", mrs_data, 0);
        end
        tick();
        chk("R8", "accept after delay", req_accept, 1);
        wake_req = 1'b0; ctl_idle = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        tick();
        chk_run_outputs("R10");
    endtask

    task automatic t_disabled();
        do_reset();
        sens_thresh = 0; ctl_idle = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            chk("R1", "disabled accept", req_accept, 1);
        end
    endtask

    task automatic t_short_idle();
        do_reset();
        pd_en = 1'b1; sens_thresh = 4; ctl_idle = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        ctl_idle = 1'b0;
        tick();
        chk("R1", "broken run", req_accept, 1);
        ctl_idle = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R1", "restarted count", req_accept, 1);
        end
        tick();
        chk("R1", "entry on fifth cycle", req_accept, 0);
    endtask

    task automatic t_full_cycle(input int thr, input int dly);
        do_reset();
        enter_sleep(thr);
        wake_up(dly);
    endtask

    task automatic t_drain_wait();
        do_reset();
        pd_en = 1'b1; sens_thresh = 1; ctl_idle = 1'b1;
        tick(); tick();
        chk("R2", "draining", req_accept, 0);
        ctl_idle = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2", "no refresh while busy", cmd_refresh, 0);
            chk("R2", "still blocked", req_accept, 0);
        end
        ctl_idle = 1'b1;
        tick();
        chk("R2", "refresh after idle", cmd_refresh, 1);
        tick();
        wake_up(0);
    endtask

    task automatic t_abandon();
        do_reset();
        pd_en = 1'b1; sens_thresh = 1; ctl_idle = 1'b1;
        tick(); tick();
        chk("R9", "in drain", req_accept, 0);
        wake_req = 1'b1;
        tick();
        chk("R9", "service resumed", req_accept, 1);
        chk("R9", "no refresh", cmd_refresh, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9", "stays in service", {req_accept, cmd_refresh}, 2);
        end
        wake_req = 1'b0; ctl_idle = 1'b0;
    endtask

    task automatic t_reset_from_sleep();
        do_reset();
        enter_sleep(2);
        rst = 1'b1;
        tick();
        rst = 1'b0; pd_en = 1'b0;
        chk_run_outputs("R10");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_disabled();
        t_short_idle();
        t_full_cycle(3, 5);
        t_full_cycle(0, 0);
        t_full_cycle(2, 200);
        t_drain_wait();
        t_abandon();
        t_reset_from_sleep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule